// File: doc/BRIEF.md
# Sprite Horizontal Position Counter

This block tracks where one sprite begins on a scanline. It does not use a binary pixel counter. Instead, a short maximal-length shift register with linear feedback walks through a pseudo-random ring of states. A two-bit prescaler moves the register one step every four pixel clocks. The ring is cut to 57 states, so one lap of the counter lasts 228 pixel clocks, which is exactly one line. Each time the counter steps back into its seed state, the block raises `draw_start` for one pixel clock. The sprite shifter uses that pulse to begin drawing.

Software never writes a numeric position. Strobing `pos_strobe` snaps the counter to its seed, so the sprite lands wherever the beam is at that moment. Because the processor runs at a third of the pixel rate, that placement is coarse. Fine placement comes from a signed four-bit motion value, taken from the upper nibble of a written byte.

A later `move_strobe` arms a one-shot correction that runs during the next horizontal blank:
- A positive value adds that many extra counter clocks, so the sprite moves left, to earlier pixels.
- A negative value withholds that many clocks, so the sprite moves right.

A small state machine sequences the correction:
- `MS_IDLE`: no correction pending. `move_strobe` captures the magnitude and sign of the motion value and goes to `MS_ARMED`.
- `MS_ARMED`: waits while `hblank` is low. When `hblank` is high, it goes to `MS_IDLE` for a zero value, to `MS_ADD` for a positive value, or to `MS_HOLD` for a negative value.
- `MS_ADD`: advances the counter by two per clock.
- `MS_HOLD`: advances the counter by zero per clock.
- Both `MS_ADD` and `MS_HOLD` count the magnitude down and return to `MS_IDLE` after the last adjusted clock.

Top module: `sprite_hpos`

## Requirements
- R1: The position register is 6 bits wide and never holds zero. Starting from the seed it passes through 57 distinct states and then returns to the seed. It steps once every 4 counter advances, so one lap is 228 advances.
- R2: With no motion active, `draw_start` is a one-clock pulse that repeats every 228 pixel clocks.
- R3: A `pos_strobe` sampled at clock edge E puts the counter at the seed with the prescaler at zero. The next `draw_start` is high in the cycle that follows edge E+228.
- R4: `mot_wr` loads the motion register from `mot_data[7:4]`. Bits 3:0 of `mot_data` have no effect on the motion applied.
- R5: `mot_clr` sets the motion register to zero. When `mot_clr` and `mot_wr` are both high in the same cycle, `mot_clr` wins.
- R6: Take the motion register as two's complement m, in the range -8 to +7. After `move_strobe` and a horizontal blank, the lap that contains the correction lasts 228-m clocks. m=0 changes nothing.
- R7: A correction armed by `move_strobe` does not start while `hblank` is low. Laps before the first high `hblank` stay at 228 clocks.
- R8: A correction is applied once. The laps after it are 228 clocks again, and the motion register keeps its value.
- R9: While reset is active, `draw_start` is low and the motion register is zero. After reset is released, the counter is at the seed, so the first pulse follows 228 clocks after release.
- R10: A `move_strobe` that arrives while a correction is pending or running is ignored. The magnitude captured first is the one applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hblank | input | 1 | High during horizontal blank; enables an armed correction |
| pos_strobe | input | 1 | Place the sprite at the current beam position |
| mot_wr | input | 1 | Load motion register from upper nibble of `mot_data` |
| mot_data | input | 8 | Written byte; bits 7:4 are the signed motion value |
| mot_clr | input | 1 | Clear motion register to zero |
| move_strobe | input | 1 | Arm a one-shot correction by the motion value |
| draw_start | output | 1 | One-clock pulse marking the sprite's first pixel |

## Verification
The assertions check the following on every cycle:
- The shift register never reaches zero.
- The register wraps from its last state back to the seed, and a strobe reloads the seed.
- `draw_start` is one cycle wide and occurs only at the seed.
- Motion-register writes and clears take the right value, and clear has priority over write.
- An armed correction holds its state until blank, and a correction ends on its final count.

Only the bench scenarios can show the line-level effects:
- The true 228-clock lap.
- The 228-clock delay from strobe to pulse.
- The exact lap shortening or stretching for each of the sixteen motion values.
- That the low nibble has no effect, that a second strobe during a pending correction is ignored, and that the correction happens only once.

// File: rtl/sprite_hpos_pkg.sv
package sprite_hpos_pkg;

    typedef enum logic [1:0] {
        MS_IDLE  = 2'd0,
        MS_ARMED = 2'd1,
        MS_ADD   = 2'd2,
        MS_HOLD  = 2'd3
    } mot_state_e;

    localparam logic [1:0] ADV_NONE = 2'd0;
    localparam logic [1:0] ADV_ONE  = 2'd1;
    localparam logic [1:0] ADV_TWO  = 2'd2;

endpackage

// File: rtl/sprite_hmotion.sv
module sprite_hmotion
    import sprite_hpos_pkg::*;
#(
    parameter int MOT_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hblank,
    input  logic              mot_wr,
    input  logic [DATA_W-1:0] mot_data,
    input  logic              mot_clr,
    input  logic              move_strobe,
    output logic [1:0]        adv
);

    localparam int NIB_LO = DATA_W - MOT_W;

    mot_state_e       state_q, state_d;
    logic [MOT_W-1:0] mot_q;
    logic [MOT_W-1:0] rem_q;
    logic             neg_q;
    logic [MOT_W-1:0] mag;

    // magnitude of the signed motion value; -2^(MOT_W-1) still fits unsigned
    always_comb begin
        if (mot_q[MOT_W-1]) mag = (~mot_q) + 1'b1;
        else                mag = mot_q;
    end

    // motion register
    always_ff @(posedge clk) begin
        if (!rst_n)       mot_q <= '0;
        else if (mot_clr) mot_q <= '0;
        else if (mot_wr)  mot_q <= mot_data[DATA_W-1:NIB_LO];
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_IDLE:  if (move_strobe) state_d = MS_ARMED;
            MS_ARMED: begin
                if (hblank) begin
                    if (rem_q == '0) state_d = MS_IDLE;
                    else if (neg_q)  state_d = MS_HOLD;
                    else             state_d = MS_ADD;
                end
            end
            MS_ADD:   if (rem_q == MOT_W'(1)) state_d = MS_IDLE;
            MS_HOLD:  if (rem_q == MOT_W'(1)) state_d = MS_IDLE;
        endcase
    end

    // state register with its remaining-count bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MS_IDLE;
            rem_q   <= '0;
            neg_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == MS_IDLE && move_strobe) begin
                rem_q <= mag;
                neg_q <= mot_q[MOT_W-1];
            end else if (state_q == MS_ADD || state_q == MS_HOLD) begin
                rem_q <= rem_q - 1'b1;
            end
        end
    end

    // outputs: counter advance per pixel clock
    always_comb begin
        unique case (state_q)
            MS_ADD:  adv = ADV_TWO;
            MS_HOLD: adv = ADV_NONE;
            default: adv = ADV_ONE;
        endcase
    end

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mot_clr |=> (mot_q == '0)); // R5
    AST_WR_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mot_wr && !mot_clr) |=> (mot_q == $past(mot_data[DATA_W-1:NIB_LO]))); // R4
    AST_WAIT_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MS_ARMED && !hblank) |=> (state_q == MS_ARMED)); // R7
    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == MS_ADD || state_q == MS_HOLD) && rem_q == MOT_W'(1)) |=> (state_q == MS_IDLE)); // R8
    AST_ADJ_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MS_ADD || state_q == MS_HOLD) |-> (rem_q != '0)); // R6
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MS_ARMED && !hblank && move_strobe) |=> $stable(rem_q)); // R10

endmodule

// File: rtl/sprite_hcount.sv
module sprite_hcount #(
    parameter int              LFSR_W      = 6,
    parameter logic [LFSR_W-1:0] TAPS      = 6'b110000,
    parameter logic [LFSR_W-1:0] SEED      = 6'b000001,
    parameter int              LINE_STATES = 57,
    parameter int              CLK_DIV     = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pos_strobe,
    input  logic [1:0] adv,
    output logic       draw_start
);

    localparam int DIV_W = $clog2(CLK_DIV);

    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] v);
        return {v[LFSR_W-2:0], ^(v & TAPS)};
    endfunction

    function automatic logic [LFSR_W-1:0] lfsr_walk(input logic [LFSR_W-1:0] v, input int n);
        logic [LFSR_W-1:0] s;
        s = v;
        for (int i = 0; i < n; i++) s = lfsr_next(s);
        return s;
    endfunction

    localparam logic [LFSR_W-1:0] LAST_ST = lfsr_walk(SEED, LINE_STATES - 1);

    logic [LFSR_W-1:0] lfsr_q;
    logic [DIV_W-1:0]  presc_q;
    logic [DIV_W:0]    sum;
    logic              step;
    logic              at_last;

    always_comb begin
        sum     = {1'b0, presc_q} + (DIV_W + 1)'(adv);
        step    = sum[DIV_W];
        at_last = (lfsr_q == LAST_ST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || pos_strobe) begin
            lfsr_q     <= SEED;
            presc_q    <= '0;
            draw_start <= 1'b0;
        end else begin
            presc_q    <= sum[DIV_W-1:0];
            draw_start <= step && at_last;
            if (step) lfsr_q <= at_last ? SEED : lfsr_next(lfsr_q);
        end
    end

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0); // R1
    AST_WRAP_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        (!pos_strobe && step && at_last) |=> (lfsr_q == SEED)); // R1
    AST_STROBE_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        pos_strobe |=> (lfsr_q == SEED && presc_q == '0)); // R3
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        draw_start |=> !draw_start); // R2
    AST_PULSE_AT_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        draw_start |-> (lfsr_q == SEED)); // R2

endmodule

// File: rtl/sprite_hpos.sv
module sprite_hpos #(
    parameter int LFSR_W      = 6,
    parameter int LINE_STATES = 57,
    parameter int CLK_DIV     = 4,
    parameter int MOT_W       = 4,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hblank,
    input  logic              pos_strobe,
    input  logic              mot_wr,
    input  logic [DATA_W-1:0] mot_data,
    input  logic              mot_clr,
    input  logic              move_strobe,
    output logic              draw_start
);

    logic [1:0] adv;

    sprite_hmotion #(
        .MOT_W  (MOT_W),
        .DATA_W (DATA_W)
    ) u_motion (
        .clk         (clk),
        .rst_n       (rst_n),
        .hblank      (hblank),
        .mot_wr      (mot_wr),
        .mot_data    (mot_data),
        .mot_clr     (mot_clr),
        .move_strobe (move_strobe),
        .adv         (adv)
    );

    sprite_hcount #(
        .LFSR_W      (LFSR_W),
        .TAPS        (LFSR_W'(6'b110000)),
        .SEED        (LFSR_W'(1)),
        .LINE_STATES (LINE_STATES),
        .CLK_DIV     (CLK_DIV)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .pos_strobe (pos_strobe),
        .adv        (adv),
        .draw_start (draw_start)
    );

    AST_ADV_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        adv <= 2'd2); // R6

endmodule

// File: tb/sim_sprite_hpos.sv
module sim_sprite_hpos;

    localparam int LINE  = 228;
    localparam int LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hblank = 1'b0;
    logic       pos_strobe = 1'b0;
    logic       mot_wr = 1'b0;
    logic [7:0] mot_data = 8'h00;
    logic       mot_clr = 1'b0;
    logic       move_strobe = 1'b0;
    logic       draw_start;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sprite_hpos u0 (
        .clk(clk), .rst_n(rst_n), .hblank(hblank), .pos_strobe(pos_strobe),
        .mot_wr(mot_wr), .mot_data(mot_data), .mot_clr(mot_clr),
        .move_strobe(move_strobe), .draw_start(draw_start)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > LIMIT) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected at most %0d", cyc, LIMIT);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse(output int at);
        @(negedge clk);
        while (!draw_start) @(negedge clk);
        at = cyc;
    endtask

    task automatic write_mot(input logic [7:0] d);
        mot_data = d; mot_wr = 1'b1;
        @(negedge clk);
        mot_wr = 1'b0;
    endtask

    task automatic strobe_move();
        move_strobe = 1'b1;
        @(negedge clk);
        move_strobe = 1'b0;
    endtask

    task automatic blank(input int n);
        hblank = 1'b1;
        repeat (n) @(negedge clk);
        hblank = 1'b0;
    endtask

    initial begin
        int t0, t1, t2, t3, rel;
        repeat (3) @(negedge clk);
        check("R9 draw_start low in reset", int'(draw_start), 0);
        rst_n = 1'b1;
        rel = cyc;
        wait_pulse(t1);
        check("R9 first pulse after reset", t1 - rel, LINE);

        // R3: strobe places the sprite now
        repeat (37) @(negedge clk);
        pos_strobe = 1'b1;
        @(negedge clk);
        t0 = cyc;
        pos_strobe = 1'b0;
        wait_pulse(t1);
        check("R3 strobe to pulse", t1 - t0, LINE);
        wait_pulse(t2);
        check("R2 R1 lap length", t2 - t1, LINE);
        @(negedge clk);
        check("R2 pulse one cycle wide", int'(draw_start), 0);

        // R6 R4 R8: all sixteen motion values, junk low nibble
        for (int i = 0; i < 16; i++) begin
            int m;
            m = (i > 7) ? i - 16 : i;
            wait_pulse(t1);
            write_mot({i[3:0], ~i[3:0]});
            strobe_move();
            blank(12);
            wait_pulse(t2);
            check($sformatf("R6 R4 lap with motion %0d", m), t2 - t1, LINE - m);
            wait_pulse(t3);
            check($sformatf("R8 lap after motion %0d", m), t3 - t2, LINE);
        end

        // R8: register keeps value, a fresh strobe repeats it
        wait_pulse(t1);
        write_mot(8'h2F);
        strobe_move(); blank(10);
        wait_pulse(t2);
        strobe_move(); blank(10);
        wait_pulse(t3);
        check("R8 value retained for second move", t3 - t2, LINE - 2);

        // R5: clear
        wait_pulse(t1);
        write_mot(8'h60);
        mot_clr = 1'b1; @(negedge clk); mot_clr = 1'b0;
        strobe_move(); blank(10);
        wait_pulse(t2);
        check("R5 clear gives no motion", t2 - t1, LINE);

        // R5: clear wins over write
        wait_pulse(t1);
        mot_data = 8'h50; mot_wr = 1'b1; mot_clr = 1'b1;
        @(negedge clk);
        mot_wr = 1'b0; mot_clr = 1'b0;
        strobe_move(); blank(10);
        wait_pulse(t2);
        check("R5 clear priority over write", t2 - t1, LINE);

        // R7: deferred until blank
        wait_pulse(t1);
        write_mot(8'h30);
        strobe_move();
        wait_pulse(t2);
        check("R7 no change without blank", t2 - t1, LINE);
        blank(10);
        wait_pulse(t3);
        check("R7 applied at blank", t3 - t2, LINE - 3);

        // R10: second strobe while pending ignored
        wait_pulse(t1);
        write_mot(8'h30);
        strobe_move();
        write_mot(8'hB0);
        strobe_move();
        blank(12);
        wait_pulse(t2);
        check("R10 pending strobe ignored", t2 - t1, LINE - 3);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule